// File: doc/BRIEF.md
# Stored Duty Sequence Player

The block plays back a stored waveform of complementary duty values for a current-sensorless power factor corrector. One utility half-period is split into 1000 switching periods, and the table holds one complementary value (1 - d) for each of them. A strobe marks each switching period. On each strobe the player moves to the next table entry. It scales that entry by a regulator gain k and hands the PWM stage the duty word 1 - (1 - d)·k. Because the table holds the complement, the entries at both ends of the half-period are zero. The duty therefore stays at full scale around each zero-crossing whatever gain the outer voltage loop selects.

Playback is kept in step with the mains by a comparator that watches the rectified input. Its output is noisy. The block passes it through a synchroniser and a stability filter. A new level is accepted only after it has held for a programmable number of clocks, and each accepted rising level gives one single-cycle restart. The restart sets the table address back to zero and takes a new gain. Between restarts the gain is frozen. If no restart arrives, playback stops on the last entry and keeps presenting it.

Duty words are unsigned fixed point with 5 fractional bits, so full scale (1000 PWM counts) is the code 32000. The gain is unsigned with 14 fractional bits, so 1.0 is the code 16384.

Top module: `duty_seq_player`

## Requirements
- R1: While reset is held and right after it, duty_out equals 32000 (full scale) and restart_o is 0.
- R2: zc_raw passes through a two-stage synchroniser. If zc_raw rises before clock edge 1 and stays high, restart_o is 1 only after edge 2+L, where L is stable_len and a value of 0 acts as 1.
- R3: A high level on zc_raw that lasts fewer than L clocks produces no restart. A level that lasts exactly L clocks produces one.
- R4: restart_o is a single-cycle pulse, given once per accepted rising level. An accepted falling level gives no pulse.
- R5: The restart sets the table address to 0. It takes priority over a period_tick in the same cycle.
- R6: Each clock with period_tick high and no restart advances the address by one. Without period_tick the address holds.
- R7: The address stops at entry 999 and stays there until the next restart.
- R8: duty_out = 32000 - min(floor(c·g / 16384), 31999), where c is the entry and g is the latched gain. duty_out shows an address two clock edges after that address was set.
- R9: The gain is sampled from gain_in only at the restart. Changes to gain_in between restarts have no effect on duty_out.
- R10: Entry i holds floor(102400·i·(999-i) / 998001) as a complementary value with 5 fractional bits. Entries 0 and 999 are zero, so they give duty_out = 32000 at any gain.
- R11: The scaled product is clamped to 31999, so duty_out never falls below 1 even at the largest gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_raw | input | 1 | Raw zero-crossing comparator level, asynchronous |
| stable_len | input | 8 | Clocks a new comparator level must hold before it is accepted (0 acts as 1) |
| period_tick | input | 1 | One-cycle strobe per switching period |
| gain_in | input | 16 | Regulator gain, 2 integer and 14 fractional bits |
| duty_out | output | 16 | Duty word for the PWM stage, 11 integer and 5 fractional bits |
| restart_o | output | 1 | Single-cycle pulse on each accepted zero-crossing |

## Verification
The hardest cases to reach from the ports are the filter boundary and the parked end of the table. A comparator pulse one clock shorter than the stability length must be dropped, and one of exactly that length must be accepted. The bench shapes zc_raw pulses of L-1 and L clocks against a known stable_len and also counts clock edges to the exact cycle of the restart. It also holds period_tick high for more than a full table after each restart, so the address runs past entry 999. That run checks the park and the end-of-table full-scale duty. It does this for a set of gains that includes one large enough to drive the product into the clamp, and it changes gain_in halfway through to show the change is ignored.

// File: rtl/duty_seq_pkg.sv
package duty_seq_pkg;

  localparam int DUTY_W    = 16;
  localparam int FRAC_W    = 5;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 14;
  localparam int PROD_W    = DUTY_W + GAIN_W;
  localparam int SHIFT_W   = PROD_W - GAIN_FRAC;

  typedef logic [DUTY_W-1:0] duty_t;
  typedef logic [GAIN_W-1:0] gain_t;

  // Complementary duty for table slot idx: a half-sine-like parabola that is
  // zero at both ends and reaches about peak at the middle.
  function automatic duty_t comp_entry(input int idx, input int n, input int peak);
    longint num;
    longint den;
    num = longint'(4 * peak) * longint'(idx) * longint'(n - 1 - idx);
    den = longint'(n - 1) * longint'(n - 1);
    return duty_t'(num / den);
  endfunction

  // Final duty: full scale minus the gain-scaled complement, clamped below full.
  function automatic duty_t scale_duty(input duty_t comp, input gain_t gain,
                                       input duty_t full);
    logic [PROD_W-1:0]  prod;
    logic [SHIFT_W-1:0] scaled;
    logic [SHIFT_W-1:0] limit;
    prod   = PROD_W'(comp) * PROD_W'(gain);
    scaled = prod[PROD_W-1:GAIN_FRAC];
    limit  = SHIFT_W'(full) - SHIFT_W'(1);
    if (scaled > limit) scaled = limit;
    return full - duty_t'(scaled);
  endfunction

endpackage

// File: rtl/zc_filter.sv
module zc_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_raw,
  input  logic [LEN_W-1:0] stable_len,
  output logic             accept_rise,
  output logic             accept_fall,
  output logic             filt_lvl,
  output logic             restart_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LEN_W-1:0]       cnt_q;
  logic [LEN_W-1:0]       len_eff;
  logic                   lvl;
  logic                   differ;
  logic                   done;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= zc_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign lvl     = sync_q[SYNC_STAGES-1];
  assign len_eff = (stable_len == '0) ? LEN_W'(1) : stable_len;
  assign differ  = (lvl != filt_lvl);
  assign done    = differ && (({1'b0, cnt_q} + (LEN_W+1)'(1)) >= {1'b0, len_eff});

  assign accept_rise = done &&  lvl;
  assign accept_fall = done && !lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_lvl  <= 1'b0;
      cnt_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= accept_rise;
      if (!differ) begin
        cnt_q <= '0;
      end else if (done) begin
        filt_lvl <= lvl;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/seq_addr.sv
module seq_addr
  import duty_seq_pkg::*;
#(
  parameter int    ENTRIES  = 1000,
  parameter int    ADDR_W   = $clog2(ENTRIES),
  parameter gain_t GAIN_NOM = gain_t'(1 << GAIN_FRAC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_evt,
  input  logic              period_tick,
  input  gain_t             gain_in,
  output logic [ADDR_W-1:0] addr,
  output gain_t             gain_q,
  output logic              at_end
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ENTRIES - 1);

  assign at_end = (addr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      gain_q <= GAIN_NOM;
    end else if (restart_evt) begin
      addr   <= '0;
      gain_q <= gain_in;
    end else if (period_tick && !at_end) begin
      addr <= addr + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/duty_rom.sv
module duty_rom
  import duty_seq_pkg::*;
#(
  parameter int ENTRIES = 1000,
  parameter int ADDR_W  = $clog2(ENTRIES),
  parameter int PEAK    = 25600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output duty_t             comp_q
);

  duty_t rom [ENTRIES];

  initial begin
    for (int i = 0; i < ENTRIES; i++) rom[i] = comp_entry(i, ENTRIES, PEAK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) comp_q <= '0;
    else        comp_q <= rom[addr];
  end

endmodule

// File: rtl/duty_scale.sv
module duty_scale
  import duty_seq_pkg::*;
#(
  parameter duty_t FULL = duty_t'(32000)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  duty_t comp_q,
  input  gain_t gain_q,
  output duty_t duty_q
);

  duty_t duty_next;

  assign duty_next = scale_duty(comp_q, gain_q, FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) duty_q <= FULL;
    else        duty_q <= duty_next;
  end

endmodule

// File: rtl/duty_seq_player.sv
module duty_seq_player
  import duty_seq_pkg::*;
#(
  parameter int ENTRIES     = 1000,
  parameter int PEAK        = 25600,
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                zc_raw,
  input  logic [LEN_W-1:0]    stable_len,
  input  logic                period_tick,
  input  logic [GAIN_W-1:0]   gain_in,
  output logic [DUTY_W-1:0]   duty_out,
  output logic                restart_o
);

  localparam int    ADDR_W = $clog2(ENTRIES);
  localparam duty_t FULL   = duty_t'(ENTRIES << FRAC_W);

  logic              restart_evt;
  logic              fall_evt;
  logic              filt_lvl;
  logic [ADDR_W-1:0] addr;
  gain_t             gain_q;
  logic              at_end;
  duty_t             comp_q;

  zc_filter #(.SYNC_STAGES(SYNC_STAGES), .LEN_W(LEN_W)) u_filt (
    .clk         (clk),
    .rst_n       (rst_n),
    .zc_raw      (zc_raw),
    .stable_len  (stable_len),
    .accept_rise (restart_evt),
    .accept_fall (fall_evt),
    .filt_lvl    (filt_lvl),
    .restart_q   (restart_o)
  );

  seq_addr #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_evt (restart_evt),
    .period_tick (period_tick),
    .gain_in     (gain_in),
    .addr        (addr),
    .gain_q      (gain_q),
    .at_end      (at_end)
  );

  duty_rom #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PEAK(PEAK)) u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .comp_q (comp_q)
  );

  duty_scale #(.FULL(FULL)) u_scale (
    .clk    (clk),
    .rst_n  (rst_n),
    .comp_q (comp_q),
    .gain_q (gain_q),
    .duty_q (duty_out)
  );

endmodule

// File: rtl/duty_seq_player_chk.sv
module duty_seq_player_chk #(
  parameter int ENTRIES = 1000,
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart_evt,
  input logic              fall_evt,
  input logic              restart_o,
  input logic              period_tick,
  input logic [ADDR_W-1:0] addr,
  input logic              at_end,
  input logic [15:0]       gain_q,
  input logic [15:0]       comp_q,
  input logic [15:0]       duty_out
);

  localparam logic [15:0] FULL = 16'(ENTRIES << FRAC_W);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);

  p_fall_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !restart_o);

  p_addr_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (addr == '0));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_tick && !restart_evt && !at_end) |=> (addr == $past(addr) + ADDR_W'(1)));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_tick && !restart_evt) |=> $stable(addr));

  p_park_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !restart_evt) |=> at_end);

  p_gain_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_evt |=> $stable(gain_q));

  p_zero_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_q == '0) |=> (duty_out == FULL));

  p_duty_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_out != '0) && (duty_out <= FULL));

endmodule

bind duty_seq_player duty_seq_player_chk #(
  .ENTRIES (ENTRIES),
  .ADDR_W  (ADDR_W),
  .FRAC_W  (duty_seq_pkg::FRAC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart_evt (restart_evt),
  .fall_evt    (fall_evt),
  .restart_o   (restart_o),
  .period_tick (period_tick),
  .addr        (addr),
  .at_end      (at_end),
  .gain_q      (gain_q),
  .comp_q      (comp_q),
  .duty_out    (duty_out)
);

// File: tb/duty_seq_player_tb.sv
module duty_seq_player_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 1000;
  localparam int FULL       = 32000;
  localparam int WATCHDOG   = 150000;

  // Vectors: gain latched at the restart, gain_in value driven mid-table.
  localparam int NV = 4;
  localparam int VEC [NV][2] = '{
    '{16384, 0},
    '{17039, 65535},
    '{15729, 16384},
    '{65535, 100}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        zc_raw = 1'b0;
  logic [7:0]  stable_len = 8'd3;
  logic        period_tick = 1'b0;
  logic [15:0] gain_in = 16'd16384;
  logic [15:0] duty_out;
  logic        restart_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  duty_seq_player u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .zc_raw      (zc_raw),
    .stable_len  (stable_len),
    .period_tick (period_tick),
    .gain_in     (gain_in),
    .duty_out    (duty_out),
    .restart_o   (restart_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual %0d expected <%0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint tab_ref(input int i);
    return (longint'(i) * longint'(999 - i) * 64'd102400) / 64'd998001;
  endfunction

  function automatic longint prod_ref(input longint c, input longint g);
    return (c * g) / 16384;
  endfunction

  function automatic longint duty_ref(input longint c, input longint g);
    longint p;
    p = prod_ref(c, g);
    if (p > FULL - 1) p = FULL - 1;
    return FULL - p;
  endfunction

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise zc_raw and wait for the restart pulse at a falling edge.
  task automatic rise_wait(output bit got);
    got = 1'b0;
    zc_raw = 1'b1;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      if (restart_o) got = 1'b1;
    end
  endtask

  initial begin
    bit got;
    bit seen;

    // R1: reset state
    negs(3);
    chk("R1 duty in reset", duty_out, FULL);
    chk("R1 restart in reset", restart_o, 0);
    rst_n = 1'b1;
    negs(2);
    chk("R1 duty after reset", duty_out, FULL);
    chk("R1 restart after reset", restart_o, 0);

    // R2: exact restart timing, L = 5
    stable_len = 8'd5;
    zc_raw = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk($sformatf("R2 L=5 edge %0d", k), restart_o, (k == 7) ? 1 : 0);
    end
    // R4: falling level gives no pulse
    zc_raw = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (restart_o) seen = 1'b1;
    end
    chk("R4 no pulse on fall", seen, 0);

    // R2: L = 0 acts as 1
    stable_len = 8'd0;
    zc_raw = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk($sformatf("R2 L=0 edge %0d", k), restart_o, (k == 3) ? 1 : 0);
    end
    zc_raw = 1'b0;
    negs(8);

    // R3: glitch of L-1 dropped, pulse of exactly L accepted
    stable_len = 8'd5;
    zc_raw = 1'b1;
    negs(4);
    zc_raw = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (restart_o) seen = 1'b1;
    end
    chk("R3 short glitch ignored", seen, 0);
    zc_raw = 1'b1;
    negs(5);
    zc_raw = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (restart_o) seen = 1'b1;
    end
    chk("R3 pulse of exactly L accepted", seen, 1);

    // R6: hold without tick, single step with one tick
    stable_len = 8'd1;
    period_tick = 1'b0;
    gain_in = 16'd20000;
    rise_wait(got);
    chk("R5 restart seen", got, 1);
    negs(2);
    for (int k = 0; k < 4; k++) begin
      chk("R6 no tick holds entry 0", duty_out, duty_ref(tab_ref(0), 20000));
      @(negedge clk);
    end
    period_tick = 1'b1;
    @(negedge clk);
    period_tick = 1'b0;
    @(negedge clk);
    chk("R6 still entry 0 in pipeline", duty_out, duty_ref(tab_ref(0), 20000));
    @(negedge clk);
    chk("R6 one tick gives entry 1", duty_out, duty_ref(tab_ref(1), 20000));
    negs(3);
    chk("R6 holds entry 1", duty_out, duty_ref(tab_ref(1), 20000));

    // R10: table end values are zero
    chk("R10 entry 0 zero", tab_ref(0), 0);
    chk("R10 entry 999 zero", tab_ref(999), 0);

    // Vector walk: full table per gain, tick held high
    stable_len = 8'd3;
    for (int v = 0; v < NV; v++) begin
      zc_raw = 1'b0;
      period_tick = 1'b1;
      gain_in = 16'(VEC[v][0]);
      seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (restart_o) seen = 1'b1;
      end
      chk($sformatf("R4 vec %0d fall silent", v), seen, 0);
      rise_wait(got);
      chk($sformatf("R5 vec %0d restart", v), got, 1);
      for (int j = 1; j <= 1006; j++) begin
        int idx;
        longint exp;
        string req;
        @(negedge clk);
        if (j == 1) chk("R4 pulse one cycle", restart_o, 0);
        if (j >= 2) begin
          idx = (j - 2 > N - 1) ? N - 1 : j - 2;
          exp = duty_ref(tab_ref(idx), VEC[v][0]);
          if (j - 2 > N - 1)                           req = "R7 park";
          else if (idx == 0)                           req = "R5 entry 0 after restart";
          else if (idx == N - 1)                       req = "R10 end entry";
          else if (prod_ref(tab_ref(idx), VEC[v][0]) > FULL - 1) req = "R11 clamp";
          else if (j > 500)                            req = "R9 gain change ignored";
          else                                         req = "R8 scaled duty";
          if (act_mismatch(duty_out, exp))
            chk($sformatf("%s vec %0d idx %0d", req, v, idx), duty_out, exp);
          else
            chk(req, duty_out, exp);
        end
        if (j == 500) gain_in = 16'(VEC[v][1]);
      end
      chk($sformatf("R7 vec %0d parked at full", v), duty_out, FULL);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic bit act_mismatch(input longint a, input longint b);
    return a != b;
  endfunction

endmodule